// File: doc/BRIEF.md
# Sequential Integer Divider with Range Trap

This block is a multi-cycle integer divider. It divides a double-width dividend by a single-width divisor and returns a single-width quotient and remainder. Three operand sizes are available: 16/8, 32/16 and 64/32 bits at the default parameter. Division can be signed or unsigned.

When the divisor is zero, or when the true quotient cannot be represented in the operand width, the block does not return results. It raises a divide-error flag instead. A mode input decides whether the most negative signed quotient counts as representable. With this input low, the most negative quotient raises the error. With it high, that value is returned normally.

An operation begins with a one-cycle start request while the unit is idle. The unit then computes one quotient bit per clock on operand magnitudes. A final cycle applies the signs and the range check. Completion is signalled by a single-cycle done pulse, which carries the error flag when the operation failed.

Top module: `trap_divider`

## Requirements
- R1: `size_sel` picks the operand size. Code 0 is byte: N = W/4, so a 16/8 division at W=32. Code 1 is word: N = W/2. Code 2 is dword: N = W. Code 3 acts exactly like code 2. Only the low 2N bits of `dividend` and the low N bits of `divisor` are used. Results occupy the low N bits of `quotient` and `remainder`, and the bits above them are zero.
- R2: With `signed_en`=0, operands are unsigned and the outputs are floor(dividend/divisor) and dividend mod divisor.
- R3: With `signed_en`=1, operands are two's complement. The quotient truncates toward zero, and the remainder takes the sign of the dividend, so that dividend = divisor × quotient + remainder. Both results are N-bit two's complement.
- R4: A zero divisor always raises `div_err`.
- R5: In unsigned mode, a quotient of 2^N or more raises `div_err`.
- R6: In signed mode, a positive quotient of 2^(N-1) or more raises `div_err`. A negative quotient whose magnitude exceeds 2^(N-1) also raises `div_err`.
- R7: In signed mode, a quotient of exactly −2^(N-1) raises `div_err` when `allow_min`=0. It is returned as the value 2^(N-1) when `allow_min`=1.
- R8: `div_err` is high only together with `done`. When it is high, `quotient` and `remainder` keep the values they held before the operation.
- R9: A start seen while idle is accepted. `busy` then stays high until `done` rises, exactly N+1 clock edges after the edge that sampled start. `done` lasts one cycle. A start seen while busy is ignored and is not queued.
- R10: The operands, size, signed mode and `allow_min` are captured when start is accepted. Changes to these inputs during the operation have no effect on it.
- R11: After reset, `busy`, `done` and `div_err` are low and `quotient` and `remainder` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division (accepted when idle) |
| size_sel | input | 2 | Operand size code (0 byte, 1 word, 2/3 dword) |
| signed_en | input | 1 | 1 selects signed division |
| allow_min | input | 1 | 1 allows the most negative signed quotient |
| dividend | input | 2*W | Double-width dividend |
| divisor | input | W | Single-width divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Divide error, valid with done |
| quotient | output | W | Quotient in the low N bits |
| remainder | output | W | Remainder in the low N bits |

## Verification
The bench builds the divider at its default W=32. At that width, byte mode is 16 by 8 bits. This is small enough to sweep every divisor value against a spread of dividends in both signed and unsigned mode. The sweep covers every zero-divisor, overflow and most-negative boundary, and each result is checked against arithmetic computed in the bench from magnitudes.

Word and dword modes use the same iteration datapath with different counts. They are covered by pseudo-random operands constructed so that they mostly land in range. Directed cases pin the signed-rounding examples and the 2^N and 2^(N-1) limits.

Every operation also scrambles the inputs while the unit is busy. This shows that results depend only on the values captured at start.

// File: rtl/dv_pkg.sv
package dv_pkg;

  typedef enum logic [1:0] {
    DV_SZ_BYTE  = 2'd0,
    DV_SZ_WORD  = 2'd1,
    DV_SZ_DWORD = 2'd2,
    DV_SZ_ALT   = 2'd3
  } dv_size_e;

  typedef enum logic [1:0] {
    DV_ST_IDLE = 2'd0,
    DV_ST_RUN  = 2'd1,
    DV_ST_POST = 2'd2
  } dv_state_e;

  // Index 0..2 of the per-size variant; the spare code aliases the widest.
  function automatic logic [1:0] dv_size_idx(input dv_size_e s);
    return (s == DV_SZ_ALT) ? 2'd2 : logic'(1'b0) ? 2'd0 : 2'(s);
  endfunction

endpackage

// File: rtl/dv_operand_prep.sv
// Converts raw operands to magnitudes for the selected size and performs
// the early range test (high half of |dividend| against |divisor|).
module dv_operand_prep
  import dv_pkg::*;
#(
  parameter int W = 32
) (
  input  dv_size_e         size,
  input  logic             signed_en,
  input  logic [2*W-1:0]   dividend,
  input  logic [W-1:0]     divisor,
  output logic [W-1:0]     hi_mag,
  output logic [W-1:0]     lo_aligned,
  output logic [W-1:0]     dvs_mag,
  output logic             neg_quot,
  output logic             neg_rem,
  output logic             pre_ovf
);

  logic [W-1:0] hi_c [3];
  logic [W-1:0] lo_c [3];
  logic [W-1:0] mb_c [3];
  logic         nq_c [3];
  logic         nr_c [3];
  logic         po_c [3];

  for (genvar g = 0; g < 3; g++) begin : g_size
    localparam int N = W >> (2 - g);
    logic [2*N-1:0] a_raw;
    logic [N-1:0]   b_raw;
    logic           a_neg;
    logic           b_neg;
    logic [2*N-1:0] a_mag;
    logic [N-1:0]   b_mag;

    assign a_raw = dividend[2*N-1:0];
    assign b_raw = divisor[N-1:0];
    assign a_neg = signed_en & a_raw[2*N-1];
    assign b_neg = signed_en & b_raw[N-1];
    assign a_mag = a_neg ? (~a_raw + 1'b1) : a_raw;
    assign b_mag = b_neg ? (~b_raw + 1'b1) : b_raw;

    assign hi_c[g] = W'(a_mag[2*N-1:N]);
    assign lo_c[g] = W'(a_mag[N-1:0]) << (W - N);
    assign mb_c[g] = W'(b_mag);
    assign nq_c[g] = a_neg ^ b_neg;
    assign nr_c[g] = a_neg;
    // Quotient would reach 2^N (covers a zero divisor as well).
    assign po_c[g] = (a_mag[2*N-1:N] >= b_mag);
  end

  always_comb begin
    case (dv_size_idx(size))
      2'd0: begin
        hi_mag = hi_c[0]; lo_aligned = lo_c[0]; dvs_mag = mb_c[0];
        neg_quot = nq_c[0]; neg_rem = nr_c[0]; pre_ovf = po_c[0];
      end
      2'd1: begin
        hi_mag = hi_c[1]; lo_aligned = lo_c[1]; dvs_mag = mb_c[1];
        neg_quot = nq_c[1]; neg_rem = nr_c[1]; pre_ovf = po_c[1];
      end
      default: begin
        hi_mag = hi_c[2]; lo_aligned = lo_c[2]; dvs_mag = mb_c[2];
        neg_quot = nq_c[2]; neg_rem = nr_c[2]; pre_ovf = po_c[2];
      end
    endcase
  end

endmodule

// File: rtl/dv_restore_core.sv
// Restoring shift-subtract datapath: one quotient bit per enabled step.
// The low half of the dividend enters left-aligned in the shift register
// and quotient bits fill it from the bottom.
module dv_restore_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] dvs_in,
  output logic [W-1:0] rem_mag,
  output logic [W-1:0] quo_mag,
  output logic [W-1:0] dvs_mag
);

  logic [W-1:0] part_q, part_d;
  logic [W-1:0] shf_q, shf_d;
  logic [W-1:0] dvs_q;
  logic [W:0]   trial;
  logic [W:0]   diff;
  logic         take;

  always_comb begin
    trial  = {part_q, shf_q[W-1]};
    diff   = trial - {1'b0, dvs_q};
    take   = (trial >= {1'b0, dvs_q});
    part_d = part_q;
    shf_d  = shf_q;
    if (load) begin
      part_d = hi_in;
      shf_d  = lo_in;
    end else if (step) begin
      part_d = take ? diff[W-1:0] : trial[W-1:0];
      shf_d  = {shf_q[W-2:0], take};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      shf_q  <= '0;
    end else if (load || step) begin
      part_q <= part_d;
      shf_q  <= shf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvs_q <= '0;
    end else if (load) begin
      dvs_q <= dvs_in;
    end
  end

  assign rem_mag = part_q;
  assign quo_mag = shf_q;
  assign dvs_mag = dvs_q;

endmodule

// File: rtl/dv_result_fix.sv
// Applies signs to the magnitudes and decides the final range verdict.
module dv_result_fix
  import dv_pkg::*;
#(
  parameter int W = 32
) (
  input  dv_size_e     size,
  input  logic         signed_en,
  input  logic         allow_min,
  input  logic         neg_quot,
  input  logic         neg_rem,
  input  logic         pre_ovf,
  input  logic [W-1:0] q_mag,
  input  logic [W-1:0] r_mag,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         err
);

  logic [W-1:0] q_c [3];
  logic [W-1:0] r_c [3];
  logic         e_c [3];

  for (genvar g = 0; g < 3; g++) begin : g_size
    localparam int N = W >> (2 - g);
    logic [N-1:0] qm;
    logic [N-1:0] rm;
    logic [N-1:0] qs;
    logic [N-1:0] rs;
    logic         top_set;
    logic         low_any;
    logic         s_err;

    assign qm      = q_mag[N-1:0];
    assign rm      = r_mag[N-1:0];
    assign top_set = qm[N-1];
    assign low_any = |qm[N-2:0];
    // Positive limit is 2^(N-1)-1; negative limit is 2^(N-1) when allowed.
    assign s_err   = neg_quot ? (top_set & (low_any | ~allow_min)) : top_set;
    assign qs      = neg_quot ? (~qm + 1'b1) : qm;
    assign rs      = neg_rem  ? (~rm + 1'b1) : rm;
    assign q_c[g]  = W'(qs);
    assign r_c[g]  = W'(rs);
    assign e_c[g]  = pre_ovf | (signed_en & s_err);
  end

  always_comb begin
    case (dv_size_idx(size))
      2'd0:    begin quot = q_c[0]; rem = r_c[0]; err = e_c[0]; end
      2'd1:    begin quot = q_c[1]; rem = r_c[1]; err = e_c[1]; end
      default: begin quot = q_c[2]; rem = r_c[2]; err = e_c[2]; end
    endcase
  end

endmodule

// File: rtl/trap_divider.sv
module trap_divider
  import dv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     size_sel,
  input  logic           signed_en,
  input  logic           allow_min,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic           div_err,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder
);

  localparam int CW = $clog2(W + 1);

  dv_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  dv_size_e     size_q;
  logic         sgn_q, amin_q, nq_q, nr_q, po_q;
  logic         done_q, done_d;
  logic         err_q, err_d;
  logic [W-1:0] quot_q, quot_d;
  logic [W-1:0] rem_q, rem_d;

  logic         accept;
  logic         step;
  dv_size_e     size_in;

  logic [W-1:0] p_hi, p_lo, p_dvs;
  logic         p_nq, p_nr, p_po;
  logic [W-1:0] c_rem, c_quo, c_dvs;
  logic [W-1:0] f_quot, f_rem;
  logic         f_err;

  function automatic logic [CW-1:0] width_of(input dv_size_e s);
    case (dv_size_idx(s))
      2'd0:    return CW'(W / 4);
      2'd1:    return CW'(W / 2);
      default: return CW'(W);
    endcase
  endfunction

  assign size_in = dv_size_e'(size_sel);
  assign accept  = start && (state_q == DV_ST_IDLE);
  assign step    = (state_q == DV_ST_RUN);

  dv_operand_prep #(.W(W)) u_prep (
    .size       (size_in),
    .signed_en  (signed_en),
    .dividend   (dividend),
    .divisor    (divisor),
    .hi_mag     (p_hi),
    .lo_aligned (p_lo),
    .dvs_mag    (p_dvs),
    .neg_quot   (p_nq),
    .neg_rem    (p_nr),
    .pre_ovf    (p_po)
  );

  dv_restore_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .step    (step),
    .hi_in   (p_hi),
    .lo_in   (p_lo),
    .dvs_in  (p_dvs),
    .rem_mag (c_rem),
    .quo_mag (c_quo),
    .dvs_mag (c_dvs)
  );

  dv_result_fix #(.W(W)) u_fix (
    .size      (size_q),
    .signed_en (sgn_q),
    .allow_min (amin_q),
    .neg_quot  (nq_q),
    .neg_rem   (nr_q),
    .pre_ovf   (po_q),
    .q_mag     (c_quo),
    .r_mag     (c_rem),
    .quot      (f_quot),
    .rem       (f_rem),
    .err       (f_err)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    quot_d  = quot_q;
    rem_d   = rem_q;
    case (state_q)
      DV_ST_IDLE: begin
        if (start) begin
          state_d = DV_ST_RUN;
          cnt_d   = width_of(size_in);
        end
      end
      DV_ST_RUN: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CW'(1)) state_d = DV_ST_POST;
      end
      DV_ST_POST: begin
        state_d = DV_ST_IDLE;
        done_d  = 1'b1;
        err_d   = f_err;
        if (!f_err) begin
          quot_d = f_quot;
          rem_d  = f_rem;
        end
      end
      default: state_d = DV_ST_IDLE;
    endcase
  end

  // Control and result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DV_ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      quot_q  <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      err_q   <= err_d;
      quot_q  <= quot_d;
      rem_q   <= rem_d;
    end
  end

  // Operation attributes, captured once per accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= DV_SZ_BYTE;
      sgn_q  <= 1'b0;
      amin_q <= 1'b0;
      nq_q   <= 1'b0;
      nr_q   <= 1'b0;
      po_q   <= 1'b0;
    end else if (accept) begin
      size_q <= size_in;
      sgn_q  <= signed_en;
      amin_q <= allow_min;
      nq_q   <= p_nq;
      nr_q   <= p_nr;
      po_q   <= p_po;
    end
  end

  assign busy      = (state_q != DV_ST_IDLE);
  assign done      = done_q;
  assign div_err   = err_q;
  assign quotient  = quot_q;
  assign remainder = rem_q;

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the unit only becomes busy in response to a start request
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R8: an error is only reported with completion
  a_r8_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> done);

  // R8: a failed operation leaves the visible results untouched
  a_r8_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_err) |-> ($stable(quotient) && $stable(remainder)));

  // R2: partial remainder stays below the divisor while in range
  a_r2_partial_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DV_ST_RUN && !po_q) |-> (c_rem < c_dvs));

  // R1: byte-size results leave the upper output bits clear
  a_r1_byte_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_err && size_q == DV_SZ_BYTE) |->
      (quotient[W-1:W/4] == '0 && remainder[W-1:W/4] == '0));

endmodule

// File: tb/trap_divider_bench.sv
module trap_divider_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  size_sel;
  logic        signed_en;
  logic        allow_min;
  logic [63:0] dividend;
  logic [31:0] divisor;
  logic        busy, done, div_err;
  logic [31:0] quotient, remainder;

  always #5 clk = ~clk;

  trap_divider u_trap_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
    .signed_en(signed_en), .allow_min(allow_min), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .div_err(div_err),
    .quotient(quotient), .remainder(remainder)
  );

  int          checks = 0;
  int          fails = 0;
  bit          finished = 0;
  logic [31:0] last_q = '0;
  logic [31:0] last_r = '0;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic int nbits(input logic [1:0] sz);
    return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
  endfunction

  task automatic check_eq(input string tag, input logic [63:0] act,
                          input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference arithmetic on magnitudes
  task automatic model(input logic [1:0] sz, input bit sg, input bit am,
                       input logic [63:0] dvd, input logic [31:0] dvs,
                       output bit e, output logic [31:0] q,
                       output logic [31:0] r);
    int n = nbits(sz);
    logic [63:0] m2, mn, a, b, ma, mb, qm, rm, half;
    bit sa, sb, ng;
    m2 = (n == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2 * n)) - 1);
    mn = (64'd1 << n) - 1;
    half = 64'd1 << (n - 1);
    a = dvd & m2;
    b = {32'd0, dvs} & mn;
    sa = sg && a[2 * n - 1];
    sb = sg && b[n - 1];
    ma = sa ? ((~a + 1) & m2) : a;
    mb = sb ? ((~b + 1) & mn) : b;
    ng = sa ^ sb;
    q = '0; r = '0;
    if (mb == 0) begin
      e = 1;
    end else begin
      qm = ma / mb;
      rm = ma % mb;
      if (!sg)     e = (qm > mn);
      else if (ng) e = (qm > half) || (qm == half && !am);
      else         e = (qm >= half);
      q = 32'(ng ? ((~qm + 1) & mn) : qm);
      r = 32'(sa ? ((~rm + 1) & mn) : rm);
    end
  endtask

  // Called 1 time unit after a rising edge; returns in the same phase.
  task automatic run_op(input logic [1:0] sz, input bit sg, input bit am,
                        input logic [63:0] dvd, input logic [31:0] dvs,
                        output bit e, output logic [31:0] q,
                        output logic [31:0] r, output int lat);
    size_sel = sz; signed_en = sg; allow_min = am;
    dividend = dvd; divisor = dvs; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    // R10: scramble every captured input while busy
    dividend  = ~dvd ^ {rnd(), rnd()};
    divisor   = dvs ^ rnd();
    size_sel  = sz ^ 2'b01;
    signed_en = ~sg;
    allow_min = ~am;
    lat = 0;
    while (lat < 100) begin
      @(posedge clk); #1;
      lat++;
      if (done) break;
    end
    e = div_err; q = quotient; r = remainder;
  endtask

  task automatic run_model(input string tag, input logic [1:0] sz,
                           input bit sg, input bit am,
                           input logic [63:0] dvd, input logic [31:0] dvs);
    bit ee, ge;
    logic [31:0] eq, er, gq, gr;
    int lat;
    model(sz, sg, am, dvd, dvs, ee, eq, er);
    run_op(sz, sg, am, dvd, dvs, ge, gq, gr, lat);
    check_eq({tag, " R9 latency"}, 64'(lat), 64'(nbits(sz) + 1));
    check_eq({tag, " R4/R5/R6/R7 error"}, 64'(ge), 64'(ee));
    if (ee) begin
      check_eq({tag, " R8 hold quotient"}, 64'(gq), 64'(last_q));
      check_eq({tag, " R8 hold remainder"}, 64'(gr), 64'(last_r));
    end else begin
      check_eq({tag, " quotient"}, 64'(gq), 64'(eq));
      check_eq({tag, " remainder"}, 64'(gr), 64'(er));
      last_q = eq; last_r = er;
    end
  endtask

  task automatic lit(input string tag, input logic [1:0] sz, input bit sg,
                     input bit am, input logic [63:0] dvd,
                     input logic [31:0] dvs, input bit xe,
                     input logic [31:0] xq, input logic [31:0] xr);
    bit ge;
    logic [31:0] gq, gr;
    int lat;
    run_op(sz, sg, am, dvd, dvs, ge, gq, gr, lat);
    check_eq({tag, " error flag"}, 64'(ge), 64'(xe));
    if (xe) begin
      check_eq({tag, " R8 hold quotient"}, 64'(gq), 64'(last_q));
      check_eq({tag, " R8 hold remainder"}, 64'(gr), 64'(last_r));
    end else begin
      check_eq({tag, " quotient"}, 64'(gq), 64'(xq));
      check_eq({tag, " remainder"}, 64'(gr), 64'(xr));
      last_q = xq; last_r = xr;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ge;
    logic [31:0] gq, gr;
    int lat;
    rst_n = 1'b0; start = 1'b0; size_sel = '0; signed_en = 1'b0;
    allow_min = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(posedge clk);
    #1;
    check_eq("R11 reset busy", 64'(busy), 64'd0);
    check_eq("R11 reset done", 64'(done), 64'd0);
    check_eq("R11 reset err", 64'(div_err), 64'd0);
    check_eq("R11 reset quotient", 64'(quotient), 64'd0);
    check_eq("R11 reset remainder", 64'(remainder), 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R3 signed rounding examples (byte size)
    lit("R3 23/5",   2'd0, 1, 0, 64'h0017, 32'h05, 0, 32'h04, 32'h03);
    lit("R3 23/-5",  2'd0, 1, 0, 64'h0017, 32'hFB, 0, 32'hFC, 32'h03);
    lit("R3 -23/5",  2'd0, 1, 0, 64'hFFE9, 32'h05, 0, 32'hFC, 32'hFD);
    lit("R3 -23/-5", 2'd0, 1, 0, 64'hFFE9, 32'hFB, 0, 32'h04, 32'hFD);
    // R2 / R5 unsigned limits
    lit("R2 2550/10", 2'd0, 0, 0, 64'd2550, 32'd10, 0, 32'hFF, 32'h00);
    lit("R2 2555/10", 2'd0, 0, 0, 64'd2555, 32'd10, 0, 32'hFF, 32'h05);
    lit("R5 2560/10", 2'd0, 0, 0, 64'd2560, 32'd10, 1, 32'h0, 32'h0);
    // R6 signed limits
    lit("R6 1270/10", 2'd0, 1, 1, 64'd1270, 32'd10, 0, 32'h7F, 32'h00);
    lit("R6 1275/10", 2'd0, 1, 0, 64'd1275, 32'd10, 0, 32'h7F, 32'h05);
    lit("R6 1280/10", 2'd0, 1, 1, 64'd1280, 32'd10, 1, 32'h0, 32'h0);
    lit("R3 1270/-10", 2'd0, 1, 0, 64'd1270, 32'hF6, 0, 32'h81, 32'h00);
    lit("R3 1275/-10", 2'd0, 1, 0, 64'd1275, 32'hF6, 0, 32'h81, 32'h05);
    lit("R6 -1290/10", 2'd0, 1, 1, 64'hFAF6, 32'd10, 1, 32'h0, 32'h0);
    // R7 most negative quotient
    lit("R7 1285/-10 allowed", 2'd0, 1, 1, 64'd1285, 32'hF6, 0, 32'h80, 32'h05);
    lit("R7 1285/-10 legacy",  2'd0, 1, 0, 64'd1285, 32'hF6, 1, 32'h0, 32'h0);
    lit("R7 -1280/10 allowed", 2'd0, 1, 1, 64'hFB00, 32'd10, 0, 32'h80, 32'h00);
    lit("R7 word allowed", 2'd1, 1, 1, 64'h0000_8000, 32'hFFFF, 0, 32'h8000, 32'h0);
    lit("R7 word legacy",  2'd1, 1, 0, 64'h0000_8000, 32'hFFFF, 1, 32'h0, 32'h0);
    lit("R7 dword allowed", 2'd2, 1, 1, 64'h8000_0000, 32'hFFFF_FFFF, 0,
        32'h8000_0000, 32'h0);
    // R4 zero divisor
    lit("R4 byte zero", 2'd0, 0, 0, 64'd5, 32'hFFFF_FF00, 1, 32'h0, 32'h0);
    lit("R4 word zero", 2'd1, 1, 1, 64'd0, 32'h0, 1, 32'h0, 32'h0);
    // R1 sizes and ignored upper bits
    lit("R1 word", 2'd1, 0, 0, 64'd100000, 32'd300, 0, 32'd333, 32'd100);
    lit("R1 dword", 2'd2, 0, 0, 64'h1_0000_0000, 32'd3, 0, 32'h5555_5555, 32'd1);
    lit("R1 alias code 3", 2'd3, 0, 0, 64'h1_0000_0000, 32'd3, 0,
        32'h5555_5555, 32'd1);
    lit("R1 upper ignored", 2'd0, 0, 0, 64'hABCD_0000_0000_09F6, 32'h1234_000A,
        0, 32'hFF, 32'h00);
    // R10: inputs are scrambled during busy in every run; checked here by name
    lit("R10 captured operands", 2'd1, 1, 0, 64'hFFFF_FF9C, 32'd7, 0,
        32'hFFF2, 32'hFFFE);

    // R9: a start during busy is ignored and not queued
    size_sel = 2'd0; signed_en = 0; allow_min = 0;
    dividend = 64'd1000; divisor = 32'd7; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    @(posedge clk); #1;
    check_eq("R9 busy during run", 64'(busy), 64'd1);
    dividend = 64'd50; divisor = 32'd3; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    lat = 0;
    while (lat < 100 && !done) begin
      @(posedge clk); #1;
      lat++;
    end
    check_eq("R9 first op quotient", 64'(quotient), 64'd142);
    check_eq("R9 first op remainder", 64'(remainder), 64'd6);
    last_q = 32'd142; last_r = 32'd6;
    begin
      int extra = 0;
      for (int i = 0; i < 12; i++) begin
        @(posedge clk); #1;
        if (done || busy) extra++;
      end
      check_eq("R9 ignored start not queued", 64'(extra), 64'd0);
    end

    // Byte sweep: every divisor against a spread of dividends
    for (int sg = 0; sg < 2; sg++) begin
      for (int dv = 0; dv < 256; dv++) begin
        for (int k = 0; k < 8; k++) begin
          logic [63:0] dd;
          if (k < 3) dd = 64'(rnd() & 32'hFFFF);
          else dd = 64'((dv * ((k * 53 + dv) & 8'hFF) + (k * 7) % (dv + 1))
                        & 32'hFFFF);
          if (sg == 1 && k[0]) dd = (~dd + 1) & 64'hFFFF;
          run_model(sg ? "R3 byte sweep" : "R2 byte sweep", 2'd0, bit'(sg),
                    bit'(k[1]), dd, 32'(dv));
        end
      end
    end

    // Word and dword random operands, mostly in range
    for (int sz = 1; sz < 4; sz++) begin
      for (int i = 0; i < 200; i++) begin
        int n = nbits(2'(sz));
        logic [63:0] mn, dv, qv, dd;
        bit sg;
        mn = (64'd1 << n) - 1;
        dv = {32'd0, rnd()} & mn;
        if (i % 40 == 0) dv = 0;
        qv = {32'd0, rnd()} & (mn >> (i % 3));
        dd = dv * qv + ((dv != 0) ? ({32'd0, rnd()} % dv) : 64'd0);
        sg = rnd() > 32'h8000_0000;
        if (sg && i[0]) dd = ~dd + 1;
        if (i % 7 == 0) dd = {rnd(), rnd()};
        run_model("R1 wide random", 2'(sz), sg, bit'(i[2]), dd, dv[31:0]);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule